// File: doc/BRIEF.md
# Parallel Slave Port

This block lets an external microprocessor use an 8-bit device port as a pair of data latches. The external side sees an 8-bit data bus and three active-low strobes: chip select, read and write. It may start a transfer at any moment, with no timing link to the internal clock. The internal side sees a small register bus with three addresses: data, control/status and direction.

The data address has two meanings. An internal write to it fills the outbound latch, and an internal read of it returns the inbound latch. Each completed external transfer is carried into the internal clock domain as a toggle through a two-flop synchronizer. This is where the full, overflow and interrupt flags are updated.

When the slave mode is off, the same pins work as ordinary general-purpose I/O. The direction register controls them and the strobes are ignored. The pad's tri-state buffer is modelled as separate output-data and output-enable vectors.

Top module: `par_slave_port`

## Requirements
- R1: After reset, the control/status register at address 1 reads 0 and the direction register at address 2 reads all ones (1 = input). The pad enable `pd_oe` is all zero. Status bits at address 1 are: bit0 mode enable, bit1 input-full, bit2 output-full, bit3 overflow, bit4 interrupt.
- R2: An internal write to address 0 loads the outbound latch and sets output-full. While the mode is on, `pd_out` carries that latch during an external read.
- R3: While the mode is on, `pd_oe` is all ones only while both `cs_n` and `rd_n` are low. At all other times it is all zero, whatever the direction register holds.
- R4: With the mode on and `cs_n` low, the rising edge of `wr_n` captures `pd_in` into the inbound latch, and input-full is set within six clocks. A write strobe while `cs_n` is high changes neither the latch nor any flag.
- R5: An internal read of address 0 returns the inbound latch (mode on) and clears input-full.
- R6: Completion of an external read (rising `rd_n` with `cs_n` low) clears output-full.
- R7: Each completed external read or write sets the interrupt bit. Writing 0 to bit4 of address 1 clears it, and writing 1 leaves it unchanged.
- R8: An external write that completes while input-full is set raises overflow. Overflow stays set through later traffic and through writes of 1 to bit3, and clears only when 0 is written to bit3.
- R9: With the mode off, `pd_oe` equals the inverted direction register and `pd_out` equals the outbound latch. A read of address 0 returns `pd_in`. Strobes leave the flags and the inbound latch unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Internal register address (0 data, 1 control/status, 2 direction) |
| bus_wr | input | 1 | Internal write strobe, one clock |
| bus_rd | input | 1 | Internal read strobe, one clock |
| bus_wdata | input | W | Internal write data |
| bus_rdata | output | W | Internal read data, combinational |
| cs_n | input | 1 | External chip select, active low |
| rd_n | input | 1 | External read strobe, active low |
| wr_n | input | 1 | External write strobe, active low |
| pd_in | input | W | Value present on the port pins |
| pd_out | output | W | Value driven onto the port pins |
| pd_oe | output | W | Per-pin output enable |

## Verification
The bench builds the block with W = 8 and SYNC_STAGES = 2. With these values each external strobe reaches the status flags within a few clocks, so a directed wait of six clocks covers every synchronizer delay. The data values are byte patterns whose set bits are easy to tell apart. These settings bring the full-flag handshake, the overflow race and the switch between slave mode and GPIO mode within reach of short directed scenarios.

// File: rtl/par_slave_port.sv
module par_slave_port #(
  parameter int W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   bus_addr,
  input  logic         bus_wr,
  input  logic         bus_rd,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  input  logic         cs_n,
  input  logic         rd_n,
  input  logic         wr_n,
  input  logic [W-1:0] pd_in,
  output logic [W-1:0] pd_out,
  output logic [W-1:0] pd_oe
);
  localparam int SH = SYNC_STAGES + 1;

  logic         mode, ibf, obf, ovf, irq;
  logic [W-1:0] out_lat, in_lat, dir;
  logic         wr_tgl, rd_tgl;
  logic [SH-1:0] wr_sync, rd_sync;
  logic         wr_evt, rd_evt;
  logic         wr_data, rd_data_i, wr_ctrl, wr_dir;

  assign wr_data   = bus_wr && bus_addr == 2'd0;
  assign rd_data_i = bus_rd && bus_addr == 2'd0;
  assign wr_ctrl   = bus_wr && bus_addr == 2'd1;
  assign wr_dir    = bus_wr && bus_addr == 2'd2;

  always_ff @(posedge wr_n or negedge rst_n)
    if (!rst_n) begin
      in_lat <= '0;
      wr_tgl <= 1'b0;
    end else if (!cs_n && mode) begin
      in_lat <= pd_in;
      wr_tgl <= ~wr_tgl;
    end

  always_ff @(posedge rd_n or negedge rst_n)
    if (!rst_n) rd_tgl <= 1'b0;
    else if (!cs_n && mode) rd_tgl <= ~rd_tgl;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wr_sync <= '0;
      rd_sync <= '0;
    end else begin
      wr_sync <= {wr_sync[SH-2:0], wr_tgl};
      rd_sync <= {rd_sync[SH-2:0], rd_tgl};
    end

  assign wr_evt = wr_sync[SH-1] ^ wr_sync[SH-2];
  assign rd_evt = rd_sync[SH-1] ^ rd_sync[SH-2];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode    <= 1'b0;
      ibf     <= 1'b0;
      obf     <= 1'b0;
      ovf     <= 1'b0;
      irq     <= 1'b0;
      out_lat <= '0;
      dir     <= '1;
    end else begin
      if (wr_data) out_lat <= bus_wdata;
      if (wr_dir)  dir <= bus_wdata;
      if (wr_ctrl) mode <= bus_wdata[0];

      if (wr_evt) ibf <= 1'b1;
      else if (rd_data_i) ibf <= 1'b0;

      if (wr_data) obf <= 1'b1;
      else if (rd_evt) obf <= 1'b0;

      if (wr_evt && ibf) ovf <= 1'b1;
      else if (wr_ctrl && !bus_wdata[3]) ovf <= 1'b0;

      if (wr_evt || rd_evt) irq <= 1'b1;
      else if (wr_ctrl && !bus_wdata[4]) irq <= 1'b0;
    end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      2'd0: bus_rdata = mode ? in_lat : pd_in;
      2'd1: bus_rdata[4:0] = {irq, ovf, obf, ibf, mode};
      2'd2: bus_rdata = dir;
      default: bus_rdata = '0;
    endcase
  end

  assign pd_out = out_lat;
  assign pd_oe  = mode ? {W{!cs_n && !rd_n}} : ~dir;

  // R3
  bus_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode && (cs_n || rd_n)) |-> pd_oe == '0);

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !(wr_ctrl && !bus_wdata[3])) |=> ovf);

  // R2
  obf_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(obf) |-> $past(wr_data));

  // R5
  ibf_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ibf) |-> $past(rd_data_i));

  // R4
  ibf_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ibf) |-> $past(wr_evt));

  // R7
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(wr_ctrl && !bus_wdata[4]));
endmodule

// File: tb/par_slave_port_tb_top.sv
module par_slave_port_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0] pd_in = '0;
  logic [7:0] pd_out, pd_oe;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  par_slave_port #(.W(8), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .pd_in(pd_in),
    .pd_out(pd_out), .pd_oe(pd_oe)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bwrite(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bread(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic ext_write(logic [7:0] d, logic sel);
    @(negedge clk);
    pd_in = d; cs_n = !sel;
    #1 wr_n = 1'b0;
    #3 wr_n = 1'b1;
    #1 cs_n = 1'b1;
    settle();
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R1 oe", pd_oe, 8'h00);
    bread(2'd1, v); check("R1 ctrl", v, 8'h00);
    bread(2'd2, v); check("R1 dir", v, 8'hFF);
    bwrite(2'd1, 8'h19);
    bread(2'd1, v); check("R1 mode on", v, 8'h01);
  endtask

  task automatic t_outbound();
    logic [7:0] v;
    bwrite(2'd0, 8'hA5);
    bread(2'd1, v); check("R2 obf", v, 8'h05);
    @(negedge clk); cs_n = 1'b0;
    #1 check("R3 cs only", pd_oe, 8'h00);
    cs_n = 1'b1; rd_n = 1'b0;
    #1 check("R3 rd only", pd_oe, 8'h00);
    cs_n = 1'b0;
    #1 check("R3 drive", pd_oe, 8'hFF);
    check("R2 data out", pd_out, 8'hA5);
    rd_n = 1'b1;
    #1 cs_n = 1'b1;
    settle();
    bread(2'd1, v); check("R6 obf clear R7 irq", v, 8'h11);
    bwrite(2'd1, 8'h09);
    bread(2'd1, v); check("R7 irq clear", v, 8'h01);
  endtask

  task automatic t_inbound();
    logic [7:0] v;
    ext_write(8'h3C, 1'b1);
    bread(2'd1, v); check("R4 ibf R7 irq", v, 8'h13);
    bread(2'd0, v); check("R5 data in", v, 8'h3C);
    bread(2'd1, v); check("R5 ibf clear", v, 8'h11);
    bwrite(2'd1, 8'h09);
    ext_write(8'h77, 1'b0);
    bread(2'd1, v); check("R4 no cs flags", v, 8'h01);
    bread(2'd0, v); check("R4 no cs latch", v, 8'h3C);
  endtask

  task automatic t_overflow();
    logic [7:0] v;
    ext_write(8'h11, 1'b1);
    ext_write(8'h22, 1'b1);
    bread(2'd1, v); check("R8 ovf set", v, 8'h1B);
    bread(2'd0, v); check("R8 last data", v, 8'h22);
    ext_write(8'h22, 1'b1);
    bread(2'd0, v);
    bread(2'd1, v); check("R8 sticky traffic", v, 8'h19);
    bwrite(2'd1, 8'h19);
    bread(2'd1, v); check("R8 write one keeps", v, 8'h19);
    bwrite(2'd1, 8'h01);
    bread(2'd1, v); check("R8 clear", v, 8'h01);
  endtask

  task automatic t_gpio();
    logic [7:0] v;
    bwrite(2'd2, 8'hF0);
    @(negedge clk); #1 check("R3 dir ignored", pd_oe, 8'h00);
    bwrite(2'd1, 8'h18);
    @(negedge clk); #1 check("R9 oe", pd_oe, 8'h0F);
    bwrite(2'd0, 8'h5A);
    check("R9 pd_out", pd_out, 8'h5A);
    pd_in = 8'hC3;
    bread(2'd0, v); check("R9 pin read", v, 8'hC3);
    ext_write(8'h99, 1'b1);
    @(negedge clk); rd_n = 1'b0; cs_n = 1'b0;
    #1 check("R9 oe under rd", pd_oe, 8'h0F);
    rd_n = 1'b1; #1 cs_n = 1'b1;
    settle();
    bread(2'd1, v); check("R9 flags", v, 8'h04);
    bwrite(2'd1, 8'h19);
    bread(2'd0, v); check("R9 latch kept", v, 8'h22);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_outbound();
    t_inbound();
    t_overflow();
    t_gpio();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule